// File: doc/BRIEF.md
# Fetch Line Instruction Splitter

This block is the second stage of an in-order instruction fetch path. It accepts whole fetched lines from the first fetch stage. Each line carries a stream number, a prediction number, the address of its first byte, a starting PC, a fault flag, one predicted-taken bit per 32-bit word and a predicted target. The block cuts each line into fixed-size 32-bit instructions and hands up to `OUT_W` of them per cycle to decode. It holds a small buffer of incoming lines. When a line is only partly used, the block keeps its place and carries on from that point in the next cycle.

The block uses two numbers to reject stale work. One is the stream number, which changes on every redirect from execute. The other is a prediction number that the block owns and bumps on every taken prediction it makes. A line from the current stream that carries an old prediction number is dropped. A line from a new stream is always accepted, and it resets both numbers and the PC. A taken prediction ends the line, sends a redirect to the first fetch stage and invalidates the held PC. A flush from execute empties the buffer. Packets are registered, so a packet appears on the outputs one clock after the edge at which its line was processed.

Top module: `fetch_splitter`

## Requirements
- R1: After reset, no output slot is valid, no redirect is signalled, `in_ready` is high and the instruction sequence number starts at 0.
- R2: A buffered line whose stream equals the last stream seen, but whose prediction number differs from the held one, is consumed with no output and leaves the held PC invalid.
- R3: The first line after reset, or a line whose stream differs from the last seen, sets the current stream, takes the line's prediction number as the held one and reloads the PC. With no valid PC, extraction starts at byte `(pc & ~3) - base` of the line.
- R4: Line word k is bits `[32k+31:32k]` of `in_data`. Slot j of a packet holds the next word in order, and its PC is the PC of slot 0 plus 4*j.
- R5: A packet fills at most `OUT_W` slots, from slot 0 upward. Unfilled slots have their valid bit low.
- R6: A line not finished within one packet keeps its byte position and its PC, and the next packet resumes at the following word.
- R7: A fault line produces exactly one slot, slot 0, with the fault bit set and the current PC. The line is then consumed and the PC becomes invalid.
- R8: For a word whose taken bit is set, its slot is marked taken and is the last valid slot. The block adds one to its prediction number and pulses `redir_valid` in the same cycle as that packet, with the line's target, the new prediction number and the line's stream. The rest of the line is dropped and the PC becomes invalid.
- R9: `exec_flush` discards every buffered line and any line offered in that cycle, produces no output, and invalidates the PC.
- R10: While `dec_ready` is low, no packet and no redirect is produced, and the buffered lines and the line position are kept.
- R11: Every emitted slot, fault slots included, takes a sequence number one above the previous emitted slot, wrapping at `SEQ_W` bits.
- R12: `in_ready` is low exactly when `DEPTH` lines are buffered. A line offered with `in_ready` high and no flush is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A line is offered |
| in_ready | output | 1 | The line buffer has room |
| in_stream | input | SEQ_W | Stream number of the line |
| in_pred | input | SEQ_W | Prediction number of the line |
| in_base | input | ADDR_W | Address of the line's first byte |
| in_pc | input | ADDR_W | PC at which execution enters the line |
| in_fault | input | 1 | The line is a fault, not data |
| in_data | input | LINE_BYTES*8 | Line contents, word 0 in the low bits |
| in_taken | input | LINE_BYTES/4 | Predicted-taken bit per word |
| in_target | input | ADDR_W | Predicted target for a taken word |
| exec_flush | input | 1 | Stream change from execute |
| dec_ready | input | 1 | Decode can take a packet this cycle |
| out_valid | output | OUT_W | Slot valid bits |
| out_fault | output | OUT_W | Slot carries a fault |
| out_taken | output | OUT_W | Slot predicted taken |
| out_inst | output | OUT_W*32 | Slot instruction words |
| out_pc | output | OUT_W*ADDR_W | Slot PCs |
| out_seq | output | OUT_W*SEQ_W | Slot sequence numbers |
| redir_valid | output | 1 | Redirect to the first fetch stage |
| redir_target | output | ADDR_W | Redirect target |
| redir_pred | output | SEQ_W | New prediction number |
| redir_stream | output | SEQ_W | Stream of the redirect |

## Verification
The bench builds the block with 16-byte lines (four words), an output width of three, a two-line buffer, 8-bit sequence numbers and 32-bit addresses. With three slots and four words, a line that starts at word 0 always splits into a three-word packet and a one-word packet, so the resume path (R6) runs often. A line that starts at word 2 fits in one packet. The two-line buffer fills after a few stalled cycles, so the `in_ready` back-pressure and flushes of a full buffer occur in both the directed and the random phases. The 8-bit sequence numbers wrap within the run.

// File: rtl/fls_pkg.sv
package fls_pkg;

  // Action taken on the head line in a given cycle.
  typedef enum logic [2:0] {
    ACT_IDLE    = 3'd0,
    ACT_FLUSH   = 3'd1,
    ACT_DROP    = 3'd2,
    ACT_FAULT   = 3'd3,
    ACT_EXTRACT = 3'd4
  } fls_act_e;

endpackage

// File: rtl/fls_line_fifo.sv
module fls_line_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             nonempty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) bump = '0;
    else                        bump = p + PTR_W'(1);
  endfunction

  assign dout     = mem[rd_q];
  assign nonempty = (cnt_q != '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (flush) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (push) wr_n = bump(wr_q);
      if (pop)  rd_n = bump(rd_q);
      if (push && !pop)      cnt_n = cnt_q + CNT_W'(1);
      else if (pop && !push) cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  // Storage needs no reset; only written entries are ever read.
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= din;
  end

endmodule

// File: rtl/fls_slice.sv
module fls_slice #(
  parameter int LINE_BYTES = 16,
  parameter int OUT_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 8
) (
  input  logic [LINE_BYTES*8-1:0]   data,
  input  logic [LINE_BYTES/4-1:0]   taken,
  input  logic [$clog2(LINE_BYTES/4)-1:0] start_word,
  input  logic [ADDR_W-1:0]         start_pc,
  input  logic [SEQ_W-1:0]          seq_base,
  output logic [OUT_W-1:0]          slot_v,
  output logic [OUT_W*32-1:0]       slot_inst,
  output logic [OUT_W*ADDR_W-1:0]   slot_pc,
  output logic [OUT_W*SEQ_W-1:0]    slot_seq,
  output logic [OUT_W-1:0]          slot_tk,
  output logic [$clog2(OUT_W+1)-1:0] used,
  output logic                      hit_taken,
  output logic                      done
);

  localparam int WORDS = LINE_BYTES / 4;
  localparam int CNT_W = $clog2(OUT_W + 1);

  always_comb begin
    logic active;
    int   n;
    int   w;
    active    = 1'b1;
    n         = 0;
    slot_v    = '0;
    slot_inst = '0;
    slot_pc   = '0;
    slot_seq  = '0;
    slot_tk   = '0;
    hit_taken = 1'b0;
    for (int k = 0; k < OUT_W; k++) begin
      w = int'(start_word) + k;
      if (active && (w < WORDS)) begin
        slot_v[k]                  = 1'b1;
        slot_inst[k*32 +: 32]      = data[w*32 +: 32];
        slot_pc[k*ADDR_W +: ADDR_W] = start_pc + ADDR_W'(k * 4);
        slot_seq[k*SEQ_W +: SEQ_W] = seq_base + SEQ_W'(k);
        slot_tk[k]                 = taken[w];
        n                          = k + 1;
        if (taken[w]) begin
          active    = 1'b0;
          hit_taken = 1'b1;
        end
      end
    end
    used = CNT_W'(n);
    done = hit_taken || ((int'(start_word) + n) >= WORDS);
  end

endmodule

// File: rtl/fetch_splitter.sv
module fetch_splitter #(
  parameter int LINE_BYTES = 16,
  parameter int OUT_W      = 2,
  parameter int DEPTH      = 2,
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SEQ_W-1:0]          in_stream,
  input  logic [SEQ_W-1:0]          in_pred,
  input  logic [ADDR_W-1:0]         in_base,
  input  logic [ADDR_W-1:0]         in_pc,
  input  logic                      in_fault,
  input  logic [LINE_BYTES*8-1:0]   in_data,
  input  logic [LINE_BYTES/4-1:0]   in_taken,
  input  logic [ADDR_W-1:0]         in_target,
  input  logic                      exec_flush,
  input  logic                      dec_ready,
  output logic [OUT_W-1:0]          out_valid,
  output logic [OUT_W-1:0]          out_fault,
  output logic [OUT_W-1:0]          out_taken,
  output logic [OUT_W*32-1:0]       out_inst,
  output logic [OUT_W*ADDR_W-1:0]   out_pc,
  output logic [OUT_W*SEQ_W-1:0]    out_seq,
  output logic                      redir_valid,
  output logic [ADDR_W-1:0]         redir_target,
  output logic [SEQ_W-1:0]          redir_pred,
  output logic [SEQ_W-1:0]          redir_stream
);

  import fls_pkg::*;

  localparam int WORDS   = LINE_BYTES / 4;
  localparam int DATA_W  = LINE_BYTES * 8;
  localparam int IDX_W   = $clog2(LINE_BYTES);
  localparam int WI_W    = $clog2(WORDS);
  localparam int CNT_W   = $clog2(OUT_W + 1);
  // Packed line layout inside the buffer.
  localparam int PC_LO   = DATA_W;
  localparam int BASE_LO = PC_LO + ADDR_W;
  localparam int STR_LO  = BASE_LO + ADDR_W;
  localparam int PRD_LO  = STR_LO + SEQ_W;
  localparam int TK_LO   = PRD_LO + SEQ_W;
  localparam int TGT_LO  = TK_LO + WORDS;
  localparam int FLT_BIT = TGT_LO + ADDR_W;
  localparam int LINE_W  = FLT_BIT + 1;

  // Buffer
  logic [LINE_W-1:0] push_line, head;
  logic              head_v, buf_full, push, pop;

  assign push_line = {in_fault, in_target, in_taken, in_pred, in_stream,
                      in_base, in_pc, in_data};
  assign push      = in_valid && !buf_full && !exec_flush;
  assign in_ready  = !buf_full;

  fls_line_fifo #(.WIDTH(LINE_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (exec_flush),
    .push     (push),
    .din      (push_line),
    .pop      (pop),
    .dout     (head),
    .nonempty (head_v),
    .full     (buf_full)
  );

  // Head line fields
  logic [DATA_W-1:0] h_data;
  logic [ADDR_W-1:0] h_pc, h_base, h_target, h_pc_al, h_off;
  logic [SEQ_W-1:0]  h_stream, h_pred;
  logic [WORDS-1:0]  h_taken;
  logic              h_fault;

  assign h_data   = head[DATA_W-1:0];
  assign h_pc     = head[PC_LO +: ADDR_W];
  assign h_base   = head[BASE_LO +: ADDR_W];
  assign h_stream = head[STR_LO +: SEQ_W];
  assign h_pred   = head[PRD_LO +: SEQ_W];
  assign h_taken  = head[TK_LO +: WORDS];
  assign h_target = head[TGT_LO +: ADDR_W];
  assign h_fault  = head[FLT_BIT];
  assign h_pc_al  = {h_pc[ADDR_W-1:2], 2'b00};
  assign h_off    = h_pc_al - h_base;

  // Tracking state
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic              have_pc_q, have_pc_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [SEQ_W-1:0]  stream_q, stream_n;
  logic              seen_q, seen_n;
  logic [SEQ_W-1:0]  pred_q, pred_n;
  logic [SEQ_W-1:0]  fseq_q, fseq_n;

  logic              new_stream, reload, stale;
  logic [SEQ_W-1:0]  eff_pred;
  logic [ADDR_W-1:0] start_pc;
  logic [IDX_W-1:0]  start_byte;
  logic [WI_W-1:0]   start_word;
  fls_act_e          act;

  assign new_stream = !seen_q || (h_stream != stream_q);
  assign stale      = !new_stream && (h_pred != pred_q);
  assign reload     = new_stream || !have_pc_q;
  assign eff_pred   = new_stream ? h_pred : pred_q;
  assign start_pc   = reload ? h_pc_al : pc_q;
  assign start_byte = reload ? h_off[IDX_W-1:0] : idx_q;
  assign start_word = start_byte[IDX_W-1:2];

  always_comb begin
    if (exec_flush)              act = ACT_FLUSH;
    else if (!dec_ready || !head_v) act = ACT_IDLE;
    else if (stale)              act = ACT_DROP;
    else if (h_fault)            act = ACT_FAULT;
    else                         act = ACT_EXTRACT;
  end

  // Extraction
  logic [OUT_W-1:0]        s_v, s_tk;
  logic [OUT_W*32-1:0]     s_inst;
  logic [OUT_W*ADDR_W-1:0] s_pc;
  logic [OUT_W*SEQ_W-1:0]  s_seq;
  logic [CNT_W-1:0]        s_used;
  logic                    s_hit, s_done;

  fls_slice #(
    .LINE_BYTES (LINE_BYTES),
    .OUT_W      (OUT_W),
    .ADDR_W     (ADDR_W),
    .SEQ_W      (SEQ_W)
  ) u_slice (
    .data       (h_data),
    .taken      (h_taken),
    .start_word (start_word),
    .start_pc   (start_pc),
    .seq_base   (fseq_q),
    .slot_v     (s_v),
    .slot_inst  (s_inst),
    .slot_pc    (s_pc),
    .slot_seq   (s_seq),
    .slot_tk    (s_tk),
    .used       (s_used),
    .hit_taken  (s_hit),
    .done       (s_done)
  );

  assign pop = (act == ACT_DROP) || (act == ACT_FAULT) ||
               ((act == ACT_EXTRACT) && s_done);

  // Next-state for tracking and output packet
  logic [OUT_W-1:0]        ov_n, of_n, ot_n;
  logic [OUT_W*32-1:0]     oi_n;
  logic [OUT_W*ADDR_W-1:0] op_n;
  logic [OUT_W*SEQ_W-1:0]  os_n;
  logic                    rv_n;
  logic [ADDR_W-1:0]       rt_n;
  logic [SEQ_W-1:0]        rp_n, rs_n;
  logic [ADDR_W-1:0]       adv_pc;

  assign adv_pc = start_pc + (ADDR_W'(s_used) << 2);

  always_comb begin
    pc_n      = pc_q;
    have_pc_n = have_pc_q;
    idx_n     = idx_q;
    stream_n  = stream_q;
    seen_n    = seen_q;
    pred_n    = pred_q;
    fseq_n    = fseq_q;
    ov_n = '0; of_n = '0; ot_n = '0; oi_n = '0; op_n = '0; os_n = '0;
    rv_n = 1'b0; rt_n = '0; rp_n = '0; rs_n = '0;
    unique case (act)
      ACT_FLUSH, ACT_DROP: begin
        have_pc_n = 1'b0;
        idx_n     = '0;
      end
      ACT_FAULT: begin
        stream_n  = h_stream;
        seen_n    = 1'b1;
        pred_n    = eff_pred;
        have_pc_n = 1'b0;
        idx_n     = '0;
        fseq_n    = fseq_q + SEQ_W'(1);
        ov_n[0]   = 1'b1;
        of_n[0]   = 1'b1;
        op_n[ADDR_W-1:0] = start_pc;
        os_n[SEQ_W-1:0]  = fseq_q;
      end
      ACT_EXTRACT: begin
        stream_n = h_stream;
        seen_n   = 1'b1;
        fseq_n   = fseq_q + SEQ_W'(s_used);
        ov_n = s_v; ot_n = s_tk; oi_n = s_inst; op_n = s_pc; os_n = s_seq;
        if (s_hit) begin
          pred_n    = eff_pred + SEQ_W'(1);
          have_pc_n = 1'b0;
          idx_n     = '0;
          rv_n      = 1'b1;
          rt_n      = h_target;
          rp_n      = eff_pred + SEQ_W'(1);
          rs_n      = h_stream;
        end else begin
          pred_n    = eff_pred;
          have_pc_n = 1'b1;
          pc_n      = adv_pc;
          idx_n     = s_done ? '0 : start_byte + (IDX_W'(s_used) << 2);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      have_pc_q <= 1'b0;
      idx_q     <= '0;
      stream_q  <= '0;
      seen_q    <= 1'b0;
      pred_q    <= '0;
      fseq_q    <= '0;
    end else begin
      pc_q      <= pc_n;
      have_pc_q <= have_pc_n;
      idx_q     <= idx_n;
      stream_q  <= stream_n;
      seen_q    <= seen_n;
      pred_q    <= pred_n;
      fseq_q    <= fseq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= '0;
      out_fault    <= '0;
      out_taken    <= '0;
      out_inst     <= '0;
      out_pc       <= '0;
      out_seq      <= '0;
      redir_valid  <= 1'b0;
      redir_target <= '0;
      redir_pred   <= '0;
      redir_stream <= '0;
    end else begin
      out_valid    <= ov_n;
      out_fault    <= of_n;
      out_taken    <= ot_n;
      out_inst     <= oi_n;
      out_pc       <= op_n;
      out_seq      <= os_n;
      redir_valid  <= rv_n;
      redir_target <= rt_n;
      redir_pred   <= rp_n;
      redir_stream <= rs_n;
    end
  end

endmodule

// File: rtl/fetch_splitter_chk.sv
module fetch_splitter_chk #(
  parameter int OUT_W = 2,
  parameter int SEQ_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dec_ready,
  input logic                     exec_flush,
  input logic [OUT_W-1:0]         out_valid,
  input logic [OUT_W-1:0]         out_fault,
  input logic [OUT_W-1:0]         out_taken,
  input logic [OUT_W*SEQ_W-1:0]   out_seq,
  input logic                     redir_valid
);

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |=> (out_valid == '0 && !redir_valid));

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_flush |=> (out_valid == '0 && !redir_valid));

  p_packed_slots_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid & (out_valid + OUT_W'(1))) == '0));

  p_fault_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_fault) |-> (out_valid == OUT_W'(1) && out_fault == OUT_W'(1)));

  p_redir_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (|(out_taken & out_valid)));

  for (genvar j = 0; j < OUT_W; j++) begin : g_last
    p_taken_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_taken[j] && out_valid[j]) |-> ((out_valid >> (j + 1)) == '0));
  end

  for (genvar j = 0; j + 1 < OUT_W; j++) begin : g_seq
    p_seq_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j+1] |->
        (out_seq[(j+1)*SEQ_W +: SEQ_W] == out_seq[j*SEQ_W +: SEQ_W] + SEQ_W'(1)));
  end

endmodule

bind fetch_splitter fetch_splitter_chk #(.OUT_W(OUT_W), .SEQ_W(SEQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_ready   (dec_ready),
  .exec_flush  (exec_flush),
  .out_valid   (out_valid),
  .out_fault   (out_fault),
  .out_taken   (out_taken),
  .out_seq     (out_seq),
  .redir_valid (redir_valid)
);

// File: tb/fetch_splitter_bench.sv
module fetch_splitter_bench;

  localparam int LB    = 16;
  localparam int OW    = 3;
  localparam int DEPTH = 2;
  localparam int AW    = 32;
  localparam int SW    = 8;
  localparam int WORDS = LB / 4;
  localparam int DW    = LB * 8;

  typedef struct {
    logic [SW-1:0]    stream;
    logic [SW-1:0]    pred;
    logic [AW-1:0]    base;
    logic [AW-1:0]    pc;
    logic [AW-1:0]    target;
    logic             fault;
    logic [WORDS-1:0] tk;
    logic [DW-1:0]    data;
  } line_t;

  logic clk, rst_n;
  logic in_valid, in_ready, in_fault, exec_flush, dec_ready;
  logic [SW-1:0] in_stream, in_pred;
  logic [AW-1:0] in_base, in_pc, in_target;
  logic [DW-1:0] in_data;
  logic [WORDS-1:0] in_taken;
  logic [OW-1:0] out_valid, out_fault, out_taken;
  logic [OW*32-1:0] out_inst;
  logic [OW*AW-1:0] out_pc;
  logic [OW*SW-1:0] out_seq;
  logic redir_valid;
  logic [AW-1:0] redir_target;
  logic [SW-1:0] redir_pred, redir_stream;

  fetch_splitter #(.LINE_BYTES(LB), .OUT_W(OW), .DEPTH(DEPTH),
                   .ADDR_W(AW), .SEQ_W(SW)) u_fetch_splitter (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  string ph = "R1 reset";

  // Reference model state
  line_t         q[$];
  logic          m_seen, m_have;
  logic [SW-1:0] m_stream, m_pred, m_fseq;
  logic [AW-1:0] m_pc;
  int            m_idx;
  // Expected registered outputs
  logic [OW-1:0] e_v, e_f, e_t;
  logic [31:0]   e_inst [OW];
  logic [AW-1:0] e_pc [OW];
  logic [SW-1:0] e_seq [OW];
  logic          e_rv;
  logic [AW-1:0] e_rt;
  logic [SW-1:0] e_rp, e_rs;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ph, act, exp);
    end
  endtask

  task automatic compare();
    for (int s = 0; s < OW; s++) begin
      chk("R5 slot valid", 64'(out_valid[s]), 64'(e_v[s]));
      if (e_v[s]) begin
        chk("R4 slot word", 64'(out_inst[s*32 +: 32]), 64'(e_inst[s]));
        chk("R4 slot pc", 64'(out_pc[s*AW +: AW]), 64'(e_pc[s]));
        chk("R11 slot seq", 64'(out_seq[s*SW +: SW]), 64'(e_seq[s]));
        chk("R7 slot fault", 64'(out_fault[s]), 64'(e_f[s]));
        chk("R8 slot taken", 64'(out_taken[s]), 64'(e_t[s]));
      end
    end
    chk("R8 redirect valid", 64'(redir_valid), 64'(e_rv));
    if (e_rv) begin
      chk("R8 redirect target", 64'(redir_target), 64'(e_rt));
      chk("R8 redirect pred", 64'(redir_pred), 64'(e_rp));
      chk("R8 redirect stream", 64'(redir_stream), 64'(e_rs));
    end
    chk("R12 in_ready", 64'(in_ready), 64'(q.size() < DEPTH));
  endtask

  task automatic model(input logic fl, input logic psh, input line_t ln, input logic rdy);
    line_t h;
    logic chg, hit;
    logic [AW-1:0] spc;
    int sb, w, n;
    e_v = '0; e_f = '0; e_t = '0; e_rv = 1'b0;
    e_rt = '0; e_rp = '0; e_rs = '0;
    for (int s = 0; s < OW; s++) begin
      e_inst[s] = '0; e_pc[s] = '0; e_seq[s] = '0;
    end
    if (fl) begin
      q.delete();
      m_have = 1'b0;
      m_idx = 0;
      return;
    end
    if (rdy && q.size() > 0) begin
      h = q[0];
      chg = !m_seen || (h.stream != m_stream);
      if (!chg && h.pred != m_pred) begin
        void'(q.pop_front());
        m_have = 1'b0;
        m_idx = 0;
      end else begin
        m_stream = h.stream;
        m_seen = 1'b1;
        if (chg) m_pred = h.pred;
        if (chg || !m_have) begin
          spc = h.pc & ~AW'(3);
          sb = int'((spc - h.base) & AW'(LB - 1));
        end else begin
          spc = m_pc;
          sb = m_idx;
        end
        if (h.fault) begin
          e_v[0] = 1'b1; e_f[0] = 1'b1; e_pc[0] = spc; e_seq[0] = m_fseq;
          m_fseq++;
          m_have = 1'b0;
          m_idx = 0;
          void'(q.pop_front());
        end else begin
          w = sb / 4; n = 0; hit = 1'b0;
          while (n < OW && w < WORDS && !hit) begin
            e_v[n] = 1'b1;
            e_inst[n] = h.data[w*32 +: 32];
            e_pc[n] = spc + AW'(4 * n);
            e_seq[n] = m_fseq + SW'(n);
            e_t[n] = h.tk[w];
            hit = h.tk[w];
            n++; w++;
          end
          m_fseq = m_fseq + SW'(n);
          if (hit) begin
            m_pred++;
            e_rv = 1'b1; e_rt = h.target; e_rp = m_pred; e_rs = h.stream;
            m_have = 1'b0; m_idx = 0;
            void'(q.pop_front());
          end else begin
            m_have = 1'b1;
            m_pc = spc + AW'(4 * n);
            if (w >= WORDS) begin
              m_idx = 0;
              void'(q.pop_front());
            end else m_idx = w * 4;
          end
        end
      end
    end
    if (psh) q.push_back(ln);
  endtask

  task automatic step(input logic fl, input logic pv, input line_t ln, input logic rdy);
    logic can;
    @(negedge clk);
    compare();
    can = (q.size() < DEPTH);
    model(fl, pv && can, ln, rdy);
    exec_flush = fl;
    in_valid   = pv;
    in_stream  = ln.stream;
    in_pred    = ln.pred;
    in_base    = ln.base;
    in_pc      = ln.pc;
    in_target  = ln.target;
    in_fault   = ln.fault;
    in_taken   = ln.tk;
    in_data    = ln.data;
    dec_ready  = rdy;
  endtask

  function automatic line_t mk(input logic [SW-1:0] st, input logic [SW-1:0] pr,
                               input logic [AW-1:0] base, input int sw,
                               input logic [WORDS-1:0] tk, input logic flt);
    line_t l;
    l.stream = st; l.pred = pr; l.base = base; l.pc = base + AW'(4 * sw);
    l.target = base + 32'h400; l.fault = flt; l.tk = tk;
    for (int k = 0; k < WORDS; k++) l.data[k*32 +: 32] = $urandom;
    return l;
  endfunction

  line_t idle_l;

  initial begin
    void'($urandom(32'd2024));
    idle_l = mk('0, '0, '0, 0, '0, 1'b0);
    q.delete();
    m_seen = 0; m_have = 0; m_stream = '0; m_pred = '0; m_fseq = '0; m_pc = '0; m_idx = 0;
    e_v = '0; e_f = '0; e_t = '0; e_rv = 0; e_rt = '0; e_rp = '0; e_rs = '0;
    for (int s = 0; s < OW; s++) begin e_inst[s] = '0; e_pc[s] = '0; e_seq[s] = '0; end
    rst_n = 1'b0; in_valid = 0; exec_flush = 0; dec_ready = 0;
    in_stream = '0; in_pred = '0; in_base = '0; in_pc = '0; in_target = '0;
    in_fault = 0; in_taken = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    ph = "R1 reset";
    step(0, 0, idle_l, 0);
    ph = "R3 new stream, entry at word 2";
    step(0, 1, mk(8'd1, 8'd5, 32'h100, 2, '0, 0), 1);
    step(0, 0, idle_l, 1);
    ph = "R6 split line resumes";
    step(0, 1, mk(8'd1, 8'd5, 32'h110, 0, '0, 0), 1);
    repeat (3) step(0, 0, idle_l, 1);
    ph = "R10 stall holds position";
    step(0, 1, mk(8'd1, 8'd5, 32'h120, 0, '0, 0), 0);
    repeat (3) step(0, 0, idle_l, 0);
    repeat (3) step(0, 0, idle_l, 1);
    ph = "R2 stale prediction dropped";
    step(0, 1, mk(8'd1, 8'd9, 32'h130, 0, '0, 0), 1);
    step(0, 1, mk(8'd1, 8'd5, 32'h140, 1, '0, 0), 1);
    repeat (3) step(0, 0, idle_l, 1);
    ph = "R8 taken word redirects";
    step(0, 1, mk(8'd1, 8'd5, 32'h150, 0, 4'b0010, 0), 0);
    step(0, 1, mk(8'd1, 8'd5, 32'h160, 0, '0, 0), 0);
    repeat (4) step(0, 0, idle_l, 1);
    ph = "R7 fault line";
    step(0, 1, mk(8'd2, 8'd7, 32'h200, 3, '0, 1), 1);
    step(0, 1, mk(8'd2, 8'd7, 32'h210, 1, '0, 0), 1);
    repeat (3) step(0, 0, idle_l, 1);
    ph = "R12 full buffer back-pressure";
    step(0, 1, mk(8'd2, 8'd7, 32'h220, 0, '0, 0), 0);
    step(0, 1, mk(8'd2, 8'd7, 32'h230, 0, '0, 0), 0);
    step(0, 1, mk(8'd2, 8'd7, 32'h240, 0, '0, 0), 0);
    ph = "R9 flush empties buffer";
    step(1, 1, mk(8'd2, 8'd7, 32'h250, 0, '0, 0), 1);
    repeat (3) step(0, 0, idle_l, 1);
    step(0, 1, mk(8'd2, 8'd7, 32'h260, 2, '0, 0), 1);
    repeat (2) step(0, 0, idle_l, 1);

    ph = "random R2 R3 R6 R9 R10 mix";
    begin
      logic [SW-1:0] g_str = 8'd3;
      logic [AW-1:0] g_addr = 32'h1000;
      for (int i = 0; i < 3000; i++) begin
        logic fl, pv, rdy, flt;
        logic [SW-1:0] pr;
        logic [WORDS-1:0] tk;
        int r, sw;
        fl  = ($urandom % 100) < 3;
        rdy = ($urandom % 100) < 75;
        pv  = ($urandom % 100) < 70;
        flt = ($urandom % 100) < 5;
        for (int k = 0; k < WORDS; k++) tk[k] = ($urandom % 100) < 8;
        r = $urandom % 100;
        sw = 0;
        pr = m_pred;
        if (r < 8) begin
          g_str++;
          pr = SW'($urandom);
          g_addr = AW'(($urandom % 256) * LB);
          sw = $urandom % WORDS;
        end else if (r < 14) begin
          pr = m_pred + SW'(1 + $urandom % 3);
        end else if (r < 20) begin
          sw = $urandom % WORDS;
        end
        step(fl, pv, mk(g_str, pr, g_addr, sw, tk, flt), rdy);
        g_addr += AW'(LB);
      end
    end
    ph = "drain";
    repeat (4) step(0, 0, idle_l, 1);
    @(negedge clk);
    compare();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule